// File: doc/BRIEF.md
# Single-Wire Debug Host Bit Engine

This block is the host-side bit engine for a single-wire, open-drain debug link. It runs on its own clock and is told, through a ratio input, how many of its own cycles make up one cycle of the target's clock. All bit timing is counted in target cycles and then converted with that ratio. A one-cycle start request launches one bit. The bit's direction and value are given with the request, and `busy` and `done` report its progress.

Every bit begins with the host pulling the wire low. A written 1 uses a short low and then an actively driven high pulse, so the wire rises quickly without waiting for a pull-up. A written 0 uses a long low that reaches past the target's sample point, followed by the same active high pulse. A read uses a short low, then releases the wire. The wire level is captured through a synchronizer ten target cycles into the bit. The time between bit starts is fixed at sixteen target cycles, which leaves room for up to one target cycle of uncertainty in when the target sees the falling edge.

Top module: `owh_bit_engine`

## Requirements
- R1: After reset `busy`, `done`, `rd_bit` and `wire_oe` are 0. While the engine is idle it never drives the wire.
- R2: A bit starts on the clock edge that samples `start`=1 while idle. From that edge on, `busy` is 1 and the wire is driven low (`wire_oe`=1, `wire_out`=0).
- R3: A write bit with `wr_bit`=1 (`rd_en`=0) drives low for 4·N host cycles, then drives high for N host cycles, then releases. N is the effective ratio.
- R4: A write bit with `wr_bit`=0 (`rd_en`=0) drives low for 13·N host cycles, then drives high for N host cycles, then releases.
- R5: A read bit (`rd_en`=1) drives low for 2·N host cycles, then releases, and never drives the wire high. `rd_bit` takes the synchronized wire level at the edge 10·N host cycles after the bit start, and holds it until the next read.
- R6: `busy` stays high for exactly 16·N host cycles. `done` is a one-cycle pulse in the first cycle after `busy` falls. A `start` given in that cycle launches the next bit with no gap.
- R7: N is the value of `ratio` at the bit start, with 0 treated as 1. Changes to `ratio`, `rd_en` or `wr_bit` while busy have no effect on the bit in flight.
- R8: `start` while busy is ignored. It neither restarts the bit nor queues a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ratio | input | RATIO_W | Host cycles per target cycle (0 treated as 1) |
| start | input | 1 | Launch one bit when idle |
| rd_en | input | 1 | 1 = read bit, 0 = write bit |
| wr_bit | input | 1 | Value to write |
| busy | output | 1 | Bit in progress |
| done | output | 1 | One-cycle end-of-bit pulse |
| rd_bit | output | 1 | Last sampled read value |
| wire_oe | output | 1 | Drive enable for the wire |
| wire_out | output | 1 | Level driven when enabled |
| wire_in | input | 1 | Wire level as seen at the pad |

## Verification
Each bit kind is measured at the pins: the number of low cycles, the number of high cycles, the phase order, and the length of `busy`. This separates a written 1, a written 0 and a read by the length of the low phase and by whether a high pulse appears. Several ratios, including 0 and 1, show whether the durations scale with N or with a constant. Reads against a target that pulls the wire low and a target that leaves it high show whether the sample is really taken from the wire. Mid-bit changes to `start`, `ratio` and `wr_bit`, and a start issued in the same cycle as `done`, separate proper latching from live decoding.

// File: rtl/owh_pkg.sv
`timescale 1ns/1ps
package owh_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2,
      PH_REL  = 2'd3
   } phase_e;
endpackage

// File: rtl/owh_sync.sv
`timescale 1ns/1ps
module owh_sync #(
   parameter int   STAGES   = 2,
   parameter logic RST_VAL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= RST_VAL;
               else        chain_q[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= RST_VAL;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/owh_tick_gen.sv
`timescale 1ns/1ps
module owh_tick_gen #(
   parameter int RATIO_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [RATIO_W-1:0] ratio,
   output logic               tick
);
   logic [RATIO_W-1:0] hcnt_q;
   logic               wrap;

   assign wrap = (hcnt_q == ratio - RATIO_W'(1));
   assign tick = run && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hcnt_q <= '0;
      else if (!run)  hcnt_q <= '0;
      else if (wrap)  hcnt_q <= '0;
      else            hcnt_q <= hcnt_q + RATIO_W'(1);
   end
endmodule

// File: rtl/owh_bit_seq.sv
`timescale 1ns/1ps
module owh_bit_seq
   import owh_pkg::*;
#(
   parameter int RATIO_W   = 8,
   parameter int BIT_T     = 16,
   parameter int W1_LOW_T  = 4,
   parameter int W0_LOW_T  = 13,
   parameter int RD_LOW_T  = 2,
   parameter int HI_T      = 1,
   parameter int SAMPLE_T  = 10,
   localparam int TCNT_W   = $clog2(BIT_T + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               rd_en,
   input  logic               wr_bit,
   input  logic [RATIO_W-1:0] ratio,
   input  logic               tick,
   input  logic               sync_in,
   output logic               busy,
   output logic               done,
   output logic               rd_bit,
   output logic               wire_oe,
   output logic               wire_out,
   output logic               dir_q,
   output logic [RATIO_W-1:0] ratio_q
);
   phase_e             phase_q, phase_d;
   logic [TCNT_W-1:0]  tcnt_q, tcnt_d, tnext, low_len;
   logic               oe_q, oe_d, out_q, out_d;
   logic               done_q, done_d, rbit_q, rbit_d;
   logic               dir_d, wbit_q, wbit_d;
   logic [RATIO_W-1:0] ratio_d;

   assign tnext   = tcnt_q + TCNT_W'(1);
   assign low_len = dir_q  ? TCNT_W'(RD_LOW_T) :
                    wbit_q ? TCNT_W'(W1_LOW_T) : TCNT_W'(W0_LOW_T);

   always_comb begin
      phase_d = phase_q;
      tcnt_d  = tcnt_q;
      oe_d    = oe_q;
      out_d   = out_q;
      done_d  = 1'b0;
      rbit_d  = rbit_q;
      dir_d   = dir_q;
      wbit_d  = wbit_q;
      ratio_d = ratio_q;
      if (phase_q == PH_IDLE) begin
         if (start) begin
            phase_d = PH_LOW;
            tcnt_d  = '0;
            oe_d    = 1'b1;
            out_d   = 1'b0;
            dir_d   = rd_en;
            wbit_d  = wr_bit;
            ratio_d = (ratio == '0) ? RATIO_W'(1) : ratio;
         end
      end else if (tick) begin
         tcnt_d = tnext;
         if (phase_q == PH_LOW && tnext == low_len) begin
            if (dir_q) begin
               oe_d    = 1'b0;
               phase_d = PH_REL;
            end else begin
               out_d   = 1'b1;
               phase_d = PH_HIGH;
            end
         end
         if (phase_q == PH_HIGH && tnext == low_len + TCNT_W'(HI_T)) begin
            oe_d    = 1'b0;
            out_d   = 1'b0;
            phase_d = PH_REL;
         end
         if (dir_q && tnext == TCNT_W'(SAMPLE_T)) rbit_d = sync_in;
         if (tnext == TCNT_W'(BIT_T)) begin
            phase_d = PH_IDLE;
            oe_d    = 1'b0;
            out_d   = 1'b0;
            done_d  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         tcnt_q  <= '0;
         oe_q    <= 1'b0;
         out_q   <= 1'b0;
         done_q  <= 1'b0;
         rbit_q  <= 1'b0;
         dir_q   <= 1'b0;
         wbit_q  <= 1'b0;
         ratio_q <= RATIO_W'(1);
      end else begin
         phase_q <= phase_d;
         tcnt_q  <= tcnt_d;
         oe_q    <= oe_d;
         out_q   <= out_d;
         done_q  <= done_d;
         rbit_q  <= rbit_d;
         dir_q   <= dir_d;
         wbit_q  <= wbit_d;
         ratio_q <= ratio_d;
      end
   end

   assign busy     = (phase_q != PH_IDLE);
   assign done     = done_q;
   assign rd_bit   = rbit_q;
   assign wire_oe  = oe_q;
   assign wire_out = out_q;
endmodule

// File: rtl/owh_bit_engine.sv
`timescale 1ns/1ps
module owh_bit_engine #(
   parameter int RATIO_W     = 8,
   parameter int SYNC_STAGES = 2,
   parameter int BIT_T       = 16,
   parameter int W1_LOW_T    = 4,
   parameter int W0_LOW_T    = 13,
   parameter int RD_LOW_T    = 2,
   parameter int HI_T        = 1,
   parameter int SAMPLE_T    = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [RATIO_W-1:0] ratio,
   input  logic               start,
   input  logic               rd_en,
   input  logic               wr_bit,
   output logic               busy,
   output logic               done,
   output logic               rd_bit,
   output logic               wire_oe,
   output logic               wire_out,
   input  logic               wire_in
);
   generate
      if (RATIO_W < 1)                  begin : g_bad_w   $error("RATIO_W must be >= 1");                    end
      if (SYNC_STAGES < 2)              begin : g_bad_s   $error("SYNC_STAGES must be >= 2");                end
      if (W1_LOW_T + HI_T > 8)          begin : g_bad_w1  $error("write-1 high must begin by target cycle 8"); end
      if (RD_LOW_T < 2 || RD_LOW_T >= 7) begin : g_bad_rd $error("read low must span 2..6 target cycles");    end
      if (W0_LOW_T <= SAMPLE_T + 1)     begin : g_bad_w0  $error("write-0 low must cover sample plus skew");  end
      if (SAMPLE_T <= RD_LOW_T)         begin : g_bad_sp  $error("sample must follow read release");          end
      if (W0_LOW_T + HI_T >= BIT_T)     begin : g_bad_bt  $error("bit period too short");                     end
   endgenerate

   logic               tick, sync_in, dir_q;
   logic [RATIO_W-1:0] ratio_q;

   owh_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk (clk), .rst_n (rst_n), .d (wire_in), .q (sync_in)
   );

   owh_tick_gen #(.RATIO_W(RATIO_W)) u_tick (
      .clk (clk), .rst_n (rst_n), .run (busy), .ratio (ratio_q), .tick (tick)
   );

   owh_bit_seq #(
      .RATIO_W (RATIO_W), .BIT_T (BIT_T), .W1_LOW_T (W1_LOW_T),
      .W0_LOW_T (W0_LOW_T), .RD_LOW_T (RD_LOW_T), .HI_T (HI_T),
      .SAMPLE_T (SAMPLE_T)
   ) u_seq (
      .clk (clk), .rst_n (rst_n), .start (start), .rd_en (rd_en),
      .wr_bit (wr_bit), .ratio (ratio), .tick (tick), .sync_in (sync_in),
      .busy (busy), .done (done), .rd_bit (rd_bit), .wire_oe (wire_oe),
      .wire_out (wire_out), .dir_q (dir_q), .ratio_q (ratio_q)
   );
endmodule

// File: rtl/owh_bit_engine_chk.sv
`timescale 1ns/1ps
module owh_bit_engine_chk #(
   parameter int RATIO_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               busy,
   input logic               done,
   input logic               wire_oe,
   input logic               wire_out,
   input logic               dir_lat,
   input logic [RATIO_W-1:0] ratio_lat
);
   logic [RATIO_W:0] hi_run_q;
   logic             drive_hi;

   assign drive_hi = wire_oe && wire_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hi_run_q <= '0;
      else if (drive_hi) hi_run_q <= hi_run_q + (RATIO_W+1)'(1);
      else               hi_run_q <= '0;
   end

   assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !wire_oe);
   assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (wire_oe && !wire_out));
   assert_high_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
      drive_hi |-> (hi_run_q < {1'b0, ratio_lat}));
   assert_read_no_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && dir_lat) |-> !drive_hi);
   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   assert_latch_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(dir_lat) && $stable(ratio_lat)));
   assert_ratio_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (ratio_lat != '0));
endmodule

bind owh_bit_engine owh_bit_engine_chk #(.RATIO_W(RATIO_W)) u_chk (
   .clk (clk), .rst_n (rst_n), .busy (busy), .done (done),
   .wire_oe (wire_oe), .wire_out (wire_out),
   .dir_lat (dir_q), .ratio_lat (ratio_q)
);

// File: tb/sim_owh_bit_engine.sv
`timescale 1ns/1ps
module sim_owh_bit_engine;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] ratio = 8'd1;
   logic       start = 1'b0, rd_en = 1'b0, wr_bit = 1'b0;
   logic       busy, done, rd_bit, wire_oe, wire_out, wire_in;
   logic       tgt_pull = 1'b0;
   int         n_run = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   assign wire_in = wire_oe ? wire_out : ~tgt_pull;

   owh_bit_engine u0 (
      .clk (clk), .rst_n (rst_n), .ratio (ratio), .start (start),
      .rd_en (rd_en), .wr_bit (wr_bit), .busy (busy), .done (done),
      .rd_bit (rd_bit), .wire_oe (wire_oe), .wire_out (wire_out),
      .wire_in (wire_in)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one bit: measure drive phases at the pins; optional mid-bit disturbances
   task automatic run_bit(input bit rd, input bit wb, input int r_in, input bit tgt_bit,
                          input bit now, input bit poke, input string tag);
      int n, busy_cnt, low_c, hi_c, order_bad, lo_exp;
      n = (r_in == 0) ? 1 : r_in;
      busy_cnt = 0; low_c = 0; hi_c = 0; order_bad = 0;
      if (!now) @(negedge clk);
      rd_en = rd; wr_bit = wb; ratio = 8'(r_in); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy && wire_oe && !wire_out, {tag, " R2 first cycle drives low"}, {busy, wire_oe, wire_out}, 3'b110);
      while (busy && busy_cnt < 5000) begin
         busy_cnt++;
         if (wire_oe && !wire_out) begin
            low_c++;
            if (hi_c != 0 || busy_cnt != low_c) order_bad++;
         end else if (wire_oe && wire_out) begin
            hi_c++;
            if (busy_cnt != low_c + hi_c) order_bad++;
         end
         tgt_pull = rd && !tgt_bit && busy_cnt >= 3*n && busy_cnt < 13*n;
         if (poke && busy_cnt == 3) begin
            start = 1'b1; wr_bit = ~wb; rd_en = ~rd; ratio = 8'(n + 3);
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      tgt_pull = 1'b0; start = 1'b0;
      lo_exp = rd ? 2*n : (wb ? 4*n : 13*n);
      chk(low_c == lo_exp, {tag, rd ? " R5 read low" : (wb ? " R3 low" : " R4 low")}, low_c, lo_exp);
      chk(hi_c == (rd ? 0 : n), {tag, rd ? " R5 no high" : (wb ? " R3 high" : " R4 high")}, hi_c, rd ? 0 : n);
      chk(order_bad == 0, {tag, " R3 R4 R5 phase order"}, order_bad, 0);
      chk(busy_cnt == 16*n, {tag, " R6 R7 busy length"}, busy_cnt, 16*n);
      chk(done == 1'b1, {tag, " R6 done at end"}, done, 1);
      if (rd) chk(rd_bit == tgt_bit, {tag, " R5 sampled bit"}, rd_bit, tgt_bit);
   endtask

   task automatic test_reset;
      chk(!busy && !done && !rd_bit && !wire_oe, "R1 reset state", {busy, done, rd_bit, wire_oe}, 0);
   endtask

   task automatic test_writes;
      run_bit(1'b0, 1'b1, 3, 1'b1, 1'b0, 1'b0, "w1 n3");
      run_bit(1'b0, 1'b0, 2, 1'b1, 1'b0, 1'b0, "w0 n2");
      run_bit(1'b0, 1'b1, 1, 1'b1, 1'b0, 1'b0, "w1 n1");
   endtask

   task automatic test_reads;
      run_bit(1'b1, 1'b0, 4, 1'b0, 1'b0, 1'b0, "rd0 n4");
      run_bit(1'b1, 1'b0, 1, 1'b1, 1'b0, 1'b0, "rd1 n1");
      run_bit(1'b1, 1'b0, 2, 1'b0, 1'b0, 1'b0, "rd0 n2");
   endtask

   task automatic test_ratio_zero;
      run_bit(1'b0, 1'b0, 0, 1'b1, 1'b0, 1'b0, "R7 ratio0");
   endtask

   task automatic test_ignored;
      run_bit(1'b0, 1'b1, 2, 1'b1, 1'b0, 1'b1, "R8 R7 poke");
      @(negedge clk);
      chk(!busy && !wire_oe, "R8 no queued bit", {busy, wire_oe}, 0);
      chk(!done, "R6 done one cycle", done, 0);
   endtask

   task automatic test_back_to_back;
      run_bit(1'b0, 1'b0, 1, 1'b1, 1'b0, 1'b0, "b2b first");
      run_bit(1'b1, 1'b0, 1, 1'b0, 1'b1, 1'b0, "R6 b2b second");
   endtask

   initial begin
      #100000;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_writes();
      test_reads();
      test_ratio_zero();
      test_ignored();
      test_back_to_back();
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule